// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Write-Cycle Busy Polling

This block is the serial front end of a small register device that sits on a two-wire open-drain bus. It oversamples the clock and data lines with the system clock and recognises bus start and stop conditions. It shifts bytes most significant bit first and checks each address byte against a fixed four-bit device type code and three strap pins. On a match it pulls the data line low in the acknowledge slot. Bytes that a master writes are handed to a register engine as simple one-cycle strobes. Read data is taken from the engine one byte at a time and shifted back out for as long as the master keeps acknowledging.

While the register engine reports that a nonvolatile write cycle is in progress, the block acknowledges no address at all. A master can therefore poll with bare address bytes, of either direction, until an acknowledge comes back. When the parallel up/down control port of the device is selected, the block ignores the bus completely and abandons any transfer it was in.

Top module: `twslv_top`

## Requirements
- R1: After reset, and until a start condition (data falling while clock is high) is seen, the block never pulls the data line low and raises no strobe, whatever bits are clocked.
- R2: An address byte whose bits 7..4 equal 0101 and whose bits 3..1 equal `devPins[2:0]` is acknowledged by pulling data low during the ninth clock high phase, for both values of bit 0 (1 = read).
- R3: An address byte with any other type code or strap bits is not acknowledged, and every later byte up to the next start condition is neither acknowledged nor reported.
- R4: While `nvBusy` is high when the eighth address bit has been taken, no address is acknowledged and no transfer begins; once `nvBusy` is low, the same address is acknowledged.
- R5: In a write transfer, the first byte after the address is reported on `addrByteStb` and every later byte on `wrDataStb`, with the value on `dataByte`. Each byte is received MSB first and acknowledged; at most one strobe is high in any cycle.
- R6: In a read transfer, the block pulses `rdTakeStb` once per byte as it captures `rdData`, and shifts that byte out MSB first. Data changes only after clock falls, and the data line only starts being pulled low while clock is low.
- R7: After a read byte, a master acknowledge (data low on the ninth clock) makes the block send the next byte; a master no-acknowledge makes it release the line and stay silent until the next start or stop.
- R8: A start condition inside a transfer, even in the middle of a byte, discards it and begins reception of a new address byte.
- R9: A stop condition (data rising while clock is high) ends the transfer and releases the line; `stopStb` pulses for it only when the transfer's address was acknowledged.
- R10: While `udSel` is high the line is released one cycle later and no strobe is raised. An aborted transfer does not resume when `udSel` falls; the block waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired with the slave pull) |
| sdaPullLow | output | 1 | 1 pulls the open-drain data line low, 0 releases it |
| devPins | input | 3 | Strap pins compared with address bits 3..1 |
| udSel | input | 1 | Parallel up/down port selected; disables the block |
| nvBusy | input | 1 | Nonvolatile write cycle in progress |
| addrByteStb | output | 1 | First written byte (register address) is on dataByte |
| wrDataStb | output | 1 | A later written byte is on dataByte |
| dataByte | output | 8 | Last byte received from the master |
| rdTakeStb | output | 1 | rdData captured for transmission; engine may advance |
| rdData | input | 8 | Next read byte from the register engine |
| stopStb | output | 1 | Stop condition that ends an acknowledged transfer |

## Verification
A wrong state in this block shows up at the ports within one bus bit time. A missed or wrong address decision changes the line level in the ninth clock high phase of that same byte. A stuck bit counter moves the acknowledge or shifts the read data by whole bit positions, which appears in the very next byte. A state that survives a no-acknowledge, a disable or a start condition shows as a line pulled low, or as a stray strobe, before the next byte is over. The sweeps therefore compare the acknowledge slot, each read bit and the strobe counts after every transaction.

// File: rtl/twslv_pkg.sv
package twslv_pkg;

  typedef enum logic [1:0] {
    DRV_NONE,
    DRV_ACK,
    DRV_DATA
  } drvMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } slvState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     shiftIn;
    logic     loadTx;
    logic     shiftTx;
    drvMode_e drv;
  } dpCtl_t;

  // Bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
    logic sclLvl;
  } busEv_t;

endpackage

// File: rtl/twslv_datapath.sv
module twslv_datapath
  import twslv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] rdData,
  output busEv_t            ev,
  output logic [DATA_W-1:0] rxByte,
  output logic              sdaPullLow
);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;

  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end
  endgenerate

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise  = sclNow & ~sclPrev;
    ev.sclFall  = ~sclNow & sclPrev;
    ev.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaBit   = sdaNow;
    ev.sclLvl   = sclNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
    end else if (ctl.shiftIn) begin
      rxShift <= {rxShift[DATA_W-2:0], sdaNow};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '1;
    end else if (ctl.loadTx) begin
      txShift <= rdData;
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign rxByte = rxShift;

  always_comb begin
    unique case (ctl.drv)
      DRV_ACK:  sdaPullLow = 1'b1;
      DRV_DATA: sdaPullLow = ~txShift[DATA_W-1];
      default:  sdaPullLow = 1'b0;
    endcase
  end

endmodule

// File: rtl/twslv_ctrl.sv
module twslv_ctrl
  import twslv_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [3:0]  TYPE_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  busEv_t            ev,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [2:0]        devPins,
  input  logic              udSel,
  input  logic              nvBusy,
  output dpCtl_t            ctl,
  output logic              addrByteStb,
  output logic              wrDataStb,
  output logic              rdTakeStb,
  output logic              stopStb
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  slvState_e state, nState;
  logic [CNT_W-1:0] bitCnt, nCnt;
  logic isRead, nRead;
  logic firstByte, nFirst;
  logic selected, nSel;
  logic doneQ, nDone;
  logic doneFirstQ, nDoneFirst;
  logic addrHit;

  assign addrHit = (rxByte[DATA_W-1 -: 4] == TYPE_CODE) &&
                   (rxByte[3:1] == devPins);

  always_comb begin
    nState     = state;
    nCnt       = bitCnt;
    nRead      = isRead;
    nFirst     = firstByte;
    nSel       = selected;
    nDone      = 1'b0;
    nDoneFirst = doneFirstQ;
    ctl        = '0;
    rdTakeStb  = 1'b0;
    stopStb    = 1'b0;

    if (udSel) begin
      nState = ST_IDLE;
      nSel   = 1'b0;
    end else if (ev.startDet) begin
      nState = ST_ADDR;
      nCnt   = '0;
      nSel   = 1'b0;
    end else if (ev.stopDet) begin
      stopStb = selected;
      nState  = ST_IDLE;
      nSel    = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (ev.sclRise) begin
            ctl.shiftIn = 1'b1;
            nCnt        = bitCnt + 1'b1;
          end else if (ev.sclFall && bitCnt == CNT_FULL) begin
            if (addrHit && !nvBusy) begin
              nState = ST_ADDR_ACK;
              nSel   = 1'b1;
              nRead  = rxByte[0];
            end else begin
              nState = ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            nCnt = '0;
            if (isRead) begin
              nState     = ST_TX;
              ctl.loadTx = 1'b1;
              rdTakeStb  = 1'b1;
            end else begin
              nState = ST_RX;
              nFirst = 1'b1;
            end
          end
        end
        ST_RX: begin
          if (ev.sclRise) begin
            ctl.shiftIn = 1'b1;
            nCnt        = bitCnt + 1'b1;
            if (bitCnt == CNT_LAST) begin
              nDone      = 1'b1;
              nDoneFirst = firstByte;
              nFirst     = 1'b0;
            end
          end else if (ev.sclFall && bitCnt == CNT_FULL) begin
            nState = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (ev.sclFall) begin
            nState = ST_RX;
            nCnt   = '0;
          end
        end
        ST_TX: begin
          if (ev.sclRise) begin
            nCnt = bitCnt + 1'b1;
          end else if (ev.sclFall) begin
            if (bitCnt == CNT_FULL) begin
              nState = ST_TX_ACK;
            end else if (bitCnt != '0) begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (ev.sclRise && ev.sdaBit) begin
            nState = ST_WAIT;
          end else if (ev.sclFall) begin
            nState     = ST_TX;
            nCnt       = '0;
            ctl.loadTx = 1'b1;
            rdTakeStb  = 1'b1;
          end
        end
        default: begin
        end
      endcase
    end

    unique case (state)
      ST_ADDR_ACK, ST_RX_ACK: ctl.drv = DRV_ACK;
      ST_TX:                  ctl.drv = DRV_DATA;
      default:                ctl.drv = DRV_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      isRead     <= 1'b0;
      firstByte  <= 1'b0;
      selected   <= 1'b0;
      doneQ      <= 1'b0;
      doneFirstQ <= 1'b0;
    end else begin
      state      <= nState;
      bitCnt     <= nCnt;
      isRead     <= nRead;
      firstByte  <= nFirst;
      selected   <= nSel;
      doneQ      <= nDone;
      doneFirstQ <= nDoneFirst;
    end
  end

  assign addrByteStb = doneQ & doneFirstQ;
  assign wrDataStb   = doneQ & ~doneFirstQ;

endmodule

// File: rtl/twslv_top.sv
module twslv_top
  import twslv_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_CODE   = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic [2:0]        devPins,
  input  logic              udSel,
  input  logic              nvBusy,
  output logic              addrByteStb,
  output logic              wrDataStb,
  output logic [DATA_W-1:0] dataByte,
  output logic              rdTakeStb,
  input  logic [DATA_W-1:0] rdData,
  output logic              stopStb
);

  dpCtl_t ctl;
  busEv_t ev;
  logic   sclLvl;

  twslv_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ctl       (ctl),
    .rdData    (rdData),
    .ev        (ev),
    .rxByte    (dataByte),
    .sdaPullLow(sdaPullLow)
  );

  twslv_ctrl #(
    .DATA_W   (DATA_W),
    .TYPE_CODE(TYPE_CODE)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .rxByte     (dataByte),
    .devPins    (devPins),
    .udSel      (udSel),
    .nvBusy     (nvBusy),
    .ctl        (ctl),
    .addrByteStb(addrByteStb),
    .wrDataStb  (wrDataStb),
    .rdTakeStb  (rdTakeStb),
    .stopStb    (stopStb)
  );

  assign sclLvl = ev.sclLvl;

endmodule

// File: rtl/twslv_checker.sv
module twslv_checker (
  input logic clk,
  input logic rst_n,
  input logic udSel,
  input logic sdaPullLow,
  input logic sclLvl,
  input logic addrByteStb,
  input logic wrDataStb,
  input logic rdTakeStb,
  input logic stopStb
);

  assert_release_when_parallel_R10: assert property (
    @(posedge clk) disable iff (!rst_n) udSel |=> !sdaPullLow
  ) else $error("line held low while parallel port selected");

  assert_quiet_when_parallel_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
      (udSel && $past(udSel)) |-> !(addrByteStb || wrDataStb || rdTakeStb || stopStb)
  ) else $error("strobe while parallel port selected");

  assert_one_strobe_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      $onehot0({addrByteStb, wrDataStb, rdTakeStb, stopStb})
  ) else $error("more than one strobe in a cycle");

  assert_release_after_stop_R9: assert property (
    @(posedge clk) disable iff (!rst_n) stopStb |=> !sdaPullLow
  ) else $error("line held low after stop");

  assert_pull_only_scl_low_R6: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(sdaPullLow) |-> !sclLvl
  ) else $error("pull started while clock high");

endmodule

bind twslv_top twslv_checker i_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .udSel      (udSel),
  .sdaPullLow (sdaPullLow),
  .sclLvl     (sclLvl),
  .addrByteStb(addrByteStb),
  .wrDataStb  (wrDataStb),
  .rdTakeStb  (rdTakeStb),
  .stopStb    (stopStb)
);

// File: tb/test_twslv_top.sv
module test_twslv_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WDOG       = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullLow;
  logic [2:0] devPins = 3'd0;
  logic udSel = 1'b0;
  logic nvBusy = 1'b0;
  logic addrByteStb, wrDataStb, rdTakeStb, stopStb;
  logic [7:0] dataByte;
  logic [7:0] rdData;

  int totalCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  int nAddr = 0, nWr = 0, nRd = 0, nStop = 0;
  logic [7:0] lastAddrByte = 8'h00;
  logic [23:0] wrHist = 24'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  function automatic logic [7:0] rdVal(input int k);
    return 8'(8'h3C ^ (k * 29));
  endfunction

  assign rdData = rdVal(nRd);

  twslv_top i_twslv_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclIn      (scl),
    .sdaIn      (sdaLine),
    .sdaPullLow (sdaPullLow),
    .devPins    (devPins),
    .udSel      (udSel),
    .nvBusy     (nvBusy),
    .addrByteStb(addrByteStb),
    .wrDataStb  (wrDataStb),
    .dataByte   (dataByte),
    .rdTakeStb  (rdTakeStb),
    .rdData     (rdData),
    .stopStb    (stopStb)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (addrByteStb) begin
        nAddr <= nAddr + 1;
        lastAddrByte <= dataByte;
      end
      if (wrDataStb) begin
        nWr <= nWr + 1;
        wrHist <= {wrHist[15:0], dataByte};
      end
      if (rdTakeStb) nRd <= nRd + 1;
      if (stopStb) nStop <= nStop + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendBit(input logic v);
    sdaM = v;
    waitHalf();
    scl = 1'b1;
    waitHalf();
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1;
    waitHalf();
    scl = 1'b1;
    waitHalf();
    ack = ~sdaLine;
    scl = 1'b0;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1;
      waitHalf();
      scl = 1'b1;
      waitHalf();
      b[i] = sdaLine;
      scl = 1'b0;
    end
    sdaM = ~ackIt;
    waitHalf();
    scl = 1'b1;
    waitHalf();
    scl = 1'b0;
    sdaM = 1'b1;
  endtask

  task automatic busStart();
    sdaM = 1'b1;
    waitHalf();
    scl = 1'b1;
    waitHalf();
    sdaM = 1'b0;
    waitHalf();
    scl = 1'b0;
  endtask

  task automatic busStop();
    sdaM = 1'b0;
    waitHalf();
    scl = 1'b1;
    waitHalf();
    sdaM = 1'b1;
    waitHalf();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!doneFlag) begin
      totalCnt++;
      failCnt++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int s0, w0, a0, r0;
    logic [7:0] bytes [4];

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(!sdaPullLow, "R1 reset pull", sdaPullLow, 0);
    chk(nAddr + nWr + nRd + nStop == 0, "R1 reset strobes", nAddr + nWr + nRd + nStop, 0);

    // R1: traffic before any start is ignored
    scl = 1'b0;
    waitHalf();
    sendByte(8'h50, ack);
    chk(!ack, "R1 no ack before start", ack, 0);
    sendByte(8'h12, ack);
    chk(!ack, "R1 no ack data before start", ack, 0);
    sdaM = 1'b1;
    waitHalf();
    scl = 1'b1;
    waitHalf();
    chk(nAddr + nWr + nRd + nStop == 0, "R1 no strobes before start", nAddr + nWr + nRd + nStop, 0);

    // R2/R3/R9: sweep strap pins x address bits x direction
    for (int p = 0; p < 8; p++) begin
      devPins = 3'(p);
      for (int a = 0; a < 8; a++) begin
        for (int rw = 0; rw < 2; rw++) begin
          s0 = nStop;
          busStart();
          sendByte({4'b0101, 3'(a), 1'(rw)}, ack);
          if (a == p) chk(ack == 1'b1, "R2 address match ack", ack, 1);
          else        chk(ack == 1'b0, "R3 strap mismatch no ack", ack, 0);
          if (ack && rw == 1) readByte(1'b0, rb);
          busStop();
          chk(nStop - s0 == ((a == p) ? 1 : 0), "R9 stop strobe only when addressed", nStop - s0, (a == p) ? 1 : 0);
        end
      end
    end

    // R3: type code sweep, then later bytes ignored
    devPins = 3'd5;
    for (int t = 0; t < 16; t++) begin
      w0 = nWr; a0 = nAddr;
      busStart();
      sendByte({4'(t), 3'd5, 1'b0}, ack);
      chk(ack == (t == 5), "R3 type code decode", ack, (t == 5) ? 1 : 0);
      if (t != 5) begin
        sendByte(8'hA7, ack);
        chk(!ack, "R3 later byte not acked", ack, 0);
        chk(nWr == w0 && nAddr == a0, "R3 later byte not reported", nWr - w0 + nAddr - a0, 0);
      end
      busStop();
    end

    // R4: busy polling
    nvBusy = 1'b1;
    for (int rw = 0; rw < 2; rw++) begin
      s0 = nStop;
      busStart();
      sendByte({4'b0101, 3'd5, 1'(rw)}, ack);
      chk(!ack, "R4 no ack while busy", ack, 0);
      busStop();
      chk(nStop == s0, "R4 no stop strobe while busy", nStop - s0, 0);
    end
    nvBusy = 1'b0;
    busStart();
    sendByte({4'b0101, 3'd5, 1'b0}, ack);
    chk(ack, "R4 ack after busy clears", ack, 1);
    busStop();

    // R5: write transfers
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) bytes[k] = 8'((s * 67 + k * 41 + 5));
      w0 = nWr; a0 = nAddr;
      busStart();
      sendByte({4'b0101, 3'd5, 1'b0}, ack);
      chk(ack, "R5 write address ack", ack, 1);
      for (int k = 0; k < 4; k++) begin
        sendByte(bytes[k], ack);
        chk(ack, "R5 write byte ack", ack, 1);
      end
      busStop();
      chk(nAddr - a0 == 1, "R5 one address strobe", nAddr - a0, 1);
      chk(lastAddrByte == bytes[0], "R5 address byte value", lastAddrByte, bytes[0]);
      chk(nWr - w0 == 3, "R5 data strobe count", nWr - w0, 3);
      chk(wrHist == {bytes[1], bytes[2], bytes[3]}, "R5 data byte values", wrHist[7:0], bytes[3]);
    end

    // R6/R7: read transfers
    for (int s = 0; s < 2; s++) begin
      r0 = nRd;
      busStart();
      sendByte({4'b0101, 3'd5, 1'b1}, ack);
      chk(ack, "R6 read address ack", ack, 1);
      for (int j = 0; j < 3 + s; j++) begin
        readByte(j != 2 + s, rb);
        chk(rb == rdVal(r0 + j), "R6 read byte MSB first", rb, rdVal(r0 + j));
      end
      chk(nRd - r0 == 3 + s, "R7 nack stops fetch", nRd - r0, 3 + s);
      for (int j = 0; j < 9; j++) begin
        sdaM = 1'b1;
        waitHalf();
        scl = 1'b1;
        waitHalf();
        if (!sdaLine) chk(1'b0, "R7 released after nack", 0, 1);
        scl = 1'b0;
      end
      chk(nRd - r0 == 3 + s, "R7 silent after nack", nRd - r0, 3 + s);
      busStop();
    end

    // R8: repeated start after a byte and in the middle of a byte
    a0 = nAddr; r0 = nRd;
    busStart();
    sendByte({4'b0101, 3'd5, 1'b0}, ack);
    sendByte(8'h11, ack);
    busStart();
    sendByte({4'b0101, 3'd5, 1'b1}, ack);
    chk(ack, "R8 restart read address ack", ack, 1);
    readByte(1'b0, rb);
    chk(rb == rdVal(r0), "R8 read after restart", rb, rdVal(r0));
    busStop();
    busStart();
    sendByte({4'b0101, 3'd5, 1'b0}, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    busStart();
    sendByte({4'b0101, 3'd5, 1'b0}, ack);
    chk(ack, "R8 mid-byte restart address ack", ack, 1);
    sendByte(8'h6B, ack);
    busStop();
    chk(lastAddrByte == 8'h6B, "R8 byte after restart", lastAddrByte, 8'h6B);
    chk(nAddr - a0 == 2, "R8 partial byte dropped", nAddr - a0, 2);

    // R10: parallel port selected
    udSel = 1'b1;
    w0 = nWr; a0 = nAddr; s0 = nStop;
    busStart();
    sendByte({4'b0101, 3'd5, 1'b0}, ack);
    chk(!ack, "R10 no ack while disabled", ack, 0);
    sendByte(8'h44, ack);
    busStop();
    chk(nWr + nAddr + nStop == w0 + a0 + s0, "R10 no strobes while disabled", nWr + nAddr + nStop - w0 - a0 - s0, 0);
    udSel = 1'b0;
    busStart();
    sendByte({4'b0101, 3'd5, 1'b0}, ack);
    chk(ack, "R10 ack before abort", ack, 1);
    udSel = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sdaPullLow, "R10 released on select", sdaPullLow, 0);
    udSel = 1'b0;
    sendByte(8'h55, ack);
    chk(!ack, "R10 aborted transfer not resumed", ack, 0);
    busStop();
    chk(nWr == w0 && nStop == s0, "R10 no strobes after abort", nWr - w0 + nStop - s0, 0);

    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule